// File: doc/BRIEF.md
# Console Serial Line Unit

This block is the console port of a small processor system. A host bus reaches it through a parallel word-register interface of four 16-bit registers: receive status, receive data, transmit status and transmit data. Behind the registers are an asynchronous transmitter and receiver. Both are paced by a shared base tick enable that is divided per direction by a 4-bit rate code. The port raises a receive request and a transmit request and presents the matching interrupt vector. It can hold the serial line in a break condition. It recognises a break arriving on its input and, when enabled, turns that break into a processor halt request.

The register window is picked by a 10-bit base value compared against address bits 12..3. The top three address bits must all be one. For the standard console window at octal 177560 the base value is 10'h3EE. Parity generation and parity checking are enabled separately. Error flags in the receive data word can be shown or masked.

Top module: `con_serial`

## Requirements
- R1: The block answers (ack_o high, rdata_o driven) only when rd_i or wr_i is set, addr_i[15:13] is 3'b111, addr_i[12:3] equals base_i and addr_i[0] is 0. addr_i[2:1] selects the register: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data. For any other address rdata_o is 0 and a write changes nothing.
- R2: In both status registers bit 7 is the read-only done/ready flag and bit 6 is a read/write interrupt enable. Transmit status bit 0 is a read/write break bit. All other bits read 0 and ignore writes. After reset the receive status reads 16'h0000 and the transmit status reads 16'h0080.
- R3: rx_irq_o is high while receive done and its enable are both set. tx_irq_o is high while transmit ready and its enable are both set. irq_vec_o is 8'o060 while rx_irq_o is set, otherwise 8'o064 while tx_irq_o is set, otherwise 0.
- R4: A write to the transmit data register while ready clears ready and sends a frame on txd_o: start bit 0, then data[7:0] LSB first, then an even parity bit if par_gen_i is set, then stop bit 1. Each bit lasts 16 sample ticks. Ready returns at the end of the stop bit. A transmit data write while not ready is ignored.
- R5: A received frame sets receive done and places the byte in receive data bits 7:0. A read of the receive data register clears done.
- R6: With par_chk_i set, the receiver expects a parity bit after the data. If data and parity hold an odd number of ones, parity error bit 12 is set.
- R7: A stop bit sampled as 0 sets framing error bit 13. A frame completed while done is still set sets overrun bit 14. Bit 15 is the OR of bits 14..12. The flags are refreshed with each frame. With err_flag_en_i low, bits 15..8 of receive data read 0.
- R8: Each direction gets one sample tick per (code+1) base ticks, where code is its 4-bit rate code. With common_speed_i set, both directions use rx_baud_i.
- R9: While transmit status bit 0 is set and brk_en_i is high, txd_o is held at 0. With brk_en_i low, the bit has no effect on txd_o.
- R10: A received frame whose data bits and stop bit are all 0 is a break. It sets done with a framing error, and halt_o equals halt_en_i from then until rxd_i has returned high.
- R11: An idle receiver ignores a low pulse on rxd_i shorter than half a bit. No frame is started and done stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero when not selected |
| ack_o | output | 1 | Access accepted by this block |
| base_i | input | 10 | Base value compared with address bits 12..3 |
| baud_tick_i | input | 1 | Base rate tick enable |
| rx_baud_i | input | 4 | Receive rate code |
| tx_baud_i | input | 4 | Transmit rate code |
| common_speed_i | input | 1 | Both directions use the receive rate code |
| par_gen_i | input | 1 | Append even parity on transmit |
| par_chk_i | input | 1 | Expect and check even parity on receive |
| err_flag_en_i | input | 1 | Show error flags in receive data high byte |
| brk_en_i | input | 1 | Permit break generation |
| halt_en_i | input | 1 | Let a received break request a halt |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| irq_vec_o | output | 8 | Vector of the pending request |
| halt_o | output | 1 | Halt request from received break |

## Verification
The hardest cases to reach are the receive error conditions, because the block only produces them from a malformed line waveform. The bench drives rxd_i bit by bit at 16 clocks per bit. It shapes frames with a wrong parity bit or a zero stop bit. It sends two frames back to back without reading in between to get an overrun. It holds the line low past a whole frame for a break, and it sends a short low glitch that must not start a frame. Break handling is checked by watching halt_o while the line is still low and again after the line is released.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int CS_ADDR_W  = 16;
  localparam int CS_BASE_W  = 10;
  localparam int CS_DATA_W  = 8;
  localparam int CS_CODE_W  = 4;
  localparam int CS_OS_RATE = 16;
  localparam int CS_VEC_W   = 8;
  localparam logic [CS_VEC_W-1:0] CS_VEC_RX = 8'o060;
  localparam logic [CS_VEC_W-1:0] CS_VEC_TX = 8'o064;

  typedef enum logic [1:0] {
    SEL_RX_STAT = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_STAT = 2'd2,
    SEL_TX_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [CS_DATA_W-1:0] data;
    logic                 pe;
    logic                 fe;
  } rx_char_t;
endpackage

// File: rtl/con_baud.sv
module con_baud #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              wrap;

  assign wrap   = (cnt_q >= code_i);
  assign tick_o = base_tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (base_tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/con_tx.sv
module con_tx #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  output logic              line_o,
  output logic              busy_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(OS_RATE);

  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q, last_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;

  assign busy_o = busy_q;
  assign line_o = busy_q ? frame_q[idx_q] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      idx_q   <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        // stop, parity (or extra stop when unused), data, start
        frame_q <= {1'b1, par_en_i ? ^data_i : 1'b1, data_i, 1'b0};
        last_q  <= par_en_i ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
        idx_q   <= '0;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(OS_RATE - 1)) begin
        if (idx_q == last_q) busy_q <= 1'b0;
        else                 idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/con_rx.sv
module con_rx
  import con_pkg::*;
#(
  parameter int DATA_W  = CS_DATA_W,
  parameter int OS_RATE = CS_OS_RATE
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic     par_en_i,
  output logic     done_o,
  output rx_char_t char_o,
  output logic     brk_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_st_e;

  rx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sr_q;
  logic              par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sr_q   <= '0;
      par_q  <= 1'b0;
      done_o <= 1'b0;
      char_o <= '0;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (st_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rxd_i) st_q <= RX_START;
          end
          RX_START: if (cnt_q == MID) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= rxd_i ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (cnt_q == LAST) begin
            sr_q <= {rxd_i, sr_q[DATA_W-1:1]};
            if (bit_q == BIT_W'(DATA_W - 1)) st_q <= par_en_i ? RX_PAR : RX_STOP;
            else                             bit_q <= bit_q + 1'b1;
          end
          RX_PAR: if (cnt_q == LAST) begin
            par_q <= rxd_i;
            st_q  <= RX_STOP;
          end
          RX_STOP: if (cnt_q == LAST) begin
            done_o      <= 1'b1;
            char_o.data <= sr_q;
            char_o.fe   <= !rxd_i;
            char_o.pe   <= par_en_i && (^sr_q ^ par_q);
            if (!rxd_i && sr_q == '0) brk_o <= 1'b1;
            st_q <= rxd_i ? RX_IDLE : RX_HOLD;
          end
          RX_HOLD: if (rxd_i) begin
            brk_o <= 1'b0;
            st_q  <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/con_serial.sv
module con_serial
  import con_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CS_ADDR_W-1:0] addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  output logic                 ack_o,
  input  logic [CS_BASE_W-1:0] base_i,
  input  logic                 baud_tick_i,
  input  logic [CS_CODE_W-1:0] rx_baud_i,
  input  logic [CS_CODE_W-1:0] tx_baud_i,
  input  logic                 common_speed_i,
  input  logic                 par_gen_i,
  input  logic                 par_chk_i,
  input  logic                 err_flag_en_i,
  input  logic                 brk_en_i,
  input  logic                 halt_en_i,
  input  logic                 rxd_i,
  output logic                 txd_o,
  output logic                 rx_irq_o,
  output logic                 tx_irq_o,
  output logic [CS_VEC_W-1:0]  irq_vec_o,
  output logic                 halt_o
);
  localparam int NDIR = 2;

  logic [CS_CODE_W-1:0] dir_code [NDIR];
  logic [NDIR-1:0]      dir_tick;

  assign dir_code[0] = rx_baud_i;
  assign dir_code[1] = common_speed_i ? rx_baud_i : tx_baud_i;

  for (genvar g = 0; g < NDIR; g++) begin : g_rate
    con_baud #(.CODE_W(CS_CODE_W)) u_baud (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .base_tick_i (baud_tick_i),
      .code_i      (dir_code[g]),
      .tick_o      (dir_tick[g])
    );
  end

  // input synchroniser
  logic [1:0] rxd_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_sync_q <= 2'b11;
    else         rxd_sync_q <= {rxd_sync_q[0], rxd_i};
  end

  // address decode
  logic     hit;
  reg_sel_e sel;
  assign hit   = (addr_i[15:13] == 3'b111) && (addr_i[12:3] == base_i) && !addr_i[0];
  assign sel   = reg_sel_e'(addr_i[2:1]);
  assign ack_o = hit && (rd_i || wr_i);

  logic wr_rx_stat, wr_tx_stat, wr_tx_data, rd_rx_data;
  assign wr_rx_stat = hit && wr_i && sel == SEL_RX_STAT;
  assign wr_tx_stat = hit && wr_i && sel == SEL_TX_STAT;
  assign wr_tx_data = hit && wr_i && sel == SEL_TX_DATA;
  assign rd_rx_data = hit && rd_i && sel == SEL_RX_DATA;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[15:8], wdata_i[5:1]};

  // transmitter
  logic tx_line, tx_busy, tx_ie_q, tx_brk_q;

  con_tx #(.DATA_W(CS_DATA_W), .OS_RATE(CS_OS_RATE)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (dir_tick[1]),
    .load_i   (wr_tx_data),
    .data_i   (wdata_i[CS_DATA_W-1:0]),
    .par_en_i (par_gen_i),
    .line_o   (tx_line),
    .busy_o   (tx_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ie_q  <= 1'b0;
      tx_brk_q <= 1'b0;
    end else if (wr_tx_stat) begin
      tx_ie_q  <= wdata_i[6];
      tx_brk_q <= wdata_i[0];
    end
  end

  assign txd_o = (tx_brk_q && brk_en_i) ? 1'b0 : tx_line;

  // receiver
  logic     rx_evt, rx_brk;
  rx_char_t rx_char;

  con_rx #(.DATA_W(CS_DATA_W), .OS_RATE(CS_OS_RATE)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (dir_tick[0]),
    .rxd_i    (rxd_sync_q[1]),
    .par_en_i (par_chk_i),
    .done_o   (rx_evt),
    .char_o   (rx_char),
    .brk_o    (rx_brk)
  );

  logic                 rx_done_q, rx_ie_q, ovr_q, fe_q, pe_q;
  logic [CS_DATA_W-1:0] rx_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_done_q <= 1'b0;
      rx_ie_q   <= 1'b0;
      ovr_q     <= 1'b0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      if (wr_rx_stat) rx_ie_q <= wdata_i[6];
      if (rx_evt) begin
        rx_done_q <= 1'b1;
        ovr_q     <= rx_done_q && !rd_rx_data;
        fe_q      <= rx_char.fe;
        pe_q      <= rx_char.pe;
        rx_buf_q  <= rx_char.data;
      end else if (rd_rx_data) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  // requests
  assign rx_irq_o  = rx_done_q && rx_ie_q;
  assign tx_irq_o  = !tx_busy && tx_ie_q;
  assign irq_vec_o = rx_irq_o ? CS_VEC_RX : (tx_irq_o ? CS_VEC_TX : '0);
  assign halt_o    = halt_en_i && rx_brk;

  // read mux
  logic [7:0] err_byte;
  assign err_byte = err_flag_en_i ? {ovr_q | fe_q | pe_q, ovr_q, fe_q, pe_q, 4'b0} : 8'h00;

  always_comb begin
    rdata_o = '0;
    if (hit && rd_i) begin
      unique case (sel)
        SEL_RX_STAT: rdata_o = {8'h00, rx_done_q, rx_ie_q, 6'b0};
        SEL_RX_DATA: rdata_o = {err_byte, rx_buf_q};
        SEL_TX_STAT: rdata_o = {8'h00, !tx_busy, tx_ie_q, 5'b0, tx_brk_q};
        SEL_TX_DATA: rdata_o = '0;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/con_serial_chk.sv
module con_serial_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  reg_sel_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic        brk_bit_i,
  input logic [15:0] rdata_o,
  input logic        ack_o,
  input logic        err_flag_en_i,
  input logic        brk_en_i,
  input logic        halt_en_i,
  input logic        txd_o,
  input logic        rx_irq_o,
  input logic        tx_irq_o,
  input logic [7:0]  irq_vec_o,
  input logic        halt_o
);
  p_quiet_miss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == 16'h0000);

  p_vec_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> irq_vec_o == 8'o060);

  p_vec_tx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_irq_o && !rx_irq_o) |-> irq_vec_o == 8'o064);

  p_tx_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && wr_i && reg_sel_i == 2'd3 && tx_irq_o) |=> !tx_irq_o);

  p_err_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && rd_i && reg_sel_i == 2'd1 && !err_flag_en_i) |-> rdata_o[15:8] == 8'h00);

  p_brk_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && wr_i && reg_sel_i == 2'd2 && brk_bit_i && brk_en_i) |=> (!brk_en_i || !txd_o));

  p_halt_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> halt_en_i);
endmodule

bind con_serial con_serial_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_sel_i     (addr_i[2:1]),
  .rd_i          (rd_i),
  .wr_i          (wr_i),
  .brk_bit_i     (wdata_i[0]),
  .rdata_o       (rdata_o),
  .ack_o         (ack_o),
  .err_flag_en_i (err_flag_en_i),
  .brk_en_i      (brk_en_i),
  .halt_en_i     (halt_en_i),
  .txd_o         (txd_o),
  .rx_irq_o      (rx_irq_o),
  .tx_irq_o      (tx_irq_o),
  .irq_vec_o     (irq_vec_o),
  .halt_o        (halt_o)
);

// File: tb/con_serial_test.sv
`timescale 1ns/1ps
module con_serial_test;
  localparam logic [15:0] A_RS = 16'o177560;
  localparam logic [15:0] A_RD = 16'o177562;
  localparam logic [15:0] A_TS = 16'o177564;
  localparam logic [15:0] A_TD = 16'o177566;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic rd = 0, wr = 0, ack;
  logic [9:0] base = 10'h3EE;
  logic [3:0] rx_baud = 4'd0, tx_baud = 4'd0;
  logic common = 0, par_gen = 0, par_chk = 0, err_en = 1, brk_en = 0, halt_en = 0;
  logic rxd = 1, txd, rx_irq, tx_irq, halt;
  logic [7:0] vec;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  con_serial uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .base_i(base),
    .baud_tick_i(1'b1), .rx_baud_i(rx_baud), .tx_baud_i(tx_baud),
    .common_speed_i(common), .par_gen_i(par_gen), .par_chk_i(par_chk),
    .err_flag_en_i(err_en), .brk_en_i(brk_en), .halt_en_i(halt_en),
    .rxd_i(rxd), .txd_o(txd), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq),
    .irq_vec_o(vec), .halt_o(halt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d, output logic k);
    @(negedge clk); addr = a; rd = 1;
    #1; d = rdata; k = ack;
    @(negedge clk); rd = 0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame at 16 clocks per bit
  task automatic rx_frame(input logic [7:0] d, input bit with_par, input bit par_val, input bit stop_val);
    @(negedge clk); rxd = 0; wait_clk(15);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_clk(16); end
    if (with_par) begin rxd = par_val; wait_clk(16); end
    rxd = stop_val; wait_clk(16);
    if (stop_val) rxd = 1;
  endtask

  // sample a frame at 16 clocks per bit right after a transmit write
  task automatic tx_expect(input string req, input logic [7:0] d, input bit with_par);
    logic [10:0] bits;
    int n;
    bits = with_par ? {1'b1, ^d, d, 1'b0} : {2'b11, d, 1'b0};
    n = with_par ? 11 : 10;
    wait_clk(8);
    for (int i = 0; i < n; i++) begin
      check(req, {15'h0, txd}, {15'h0, bits[i]});
      wait_clk(16);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d; logic k;
    bus_rd(A_RS, d, k); check("R2 rx status reset", d, 16'h0000);
    bus_rd(A_TS, d, k); check("R2 tx status reset", d, 16'h0080);
    check("R2 reset lines", {12'h0, txd, halt, rx_irq, tx_irq}, 16'h0008);
  endtask

  task automatic t_decode;
    logic [15:0] d; logic k;
    bus_rd(A_TS, d, k); check("R1 ack on match", {15'h0, k}, 16'h1);
    bus_rd(16'o077564, d, k); check("R1 top bits not ones", {k, d[14:0]}, 16'h0);
    bus_rd(16'o177664, d, k); check("R1 base mismatch", {k, d[14:0]}, 16'h0);
    bus_rd(16'o177565, d, k); check("R1 odd address", {k, d[14:0]}, 16'h0);
    bus_wr(16'o177666, 16'h0055);
    wait_clk(3);
    check("R1 miss write leaves line idle", {15'h0, txd}, 16'h1);
    bus_rd(A_TS, d, k); check("R1 miss write leaves ready", d, 16'h0080);
  endtask

  task automatic t_status_bits;
    logic [15:0] d; logic k;
    bus_wr(A_RS, 16'hFFFF);
    bus_rd(A_RS, d, k); check("R2 rx status writable bits", d, 16'h0040);
    bus_wr(A_TS, 16'hFF3F);
    bus_rd(A_TS, d, k); check("R2 tx status writable bits", d, 16'h0081);
    check("R9 break without permit", {15'h0, txd}, 16'h1);
    brk_en = 1; wait_clk(1);
    check("R9 break forces low", {15'h0, txd}, 16'h0);
    bus_wr(A_TS, 16'h0000); brk_en = 0;
    wait_clk(1);
    check("R9 break released", {15'h0, txd}, 16'h1);
    bus_wr(A_RS, 16'h0000);
  endtask

  task automatic t_tx_basic;
    logic [15:0] d; logic k;
    bus_wr(A_TD, 16'hFFA5);
    tx_expect("R4 frame A5", 8'hA5, 0);
    bus_rd(A_TS, d, k); check("R4 ready after frame", d, 16'h0080);
    bus_wr(A_TD, 16'h003C);
    bus_wr(A_TD, 16'h00FF);
    wait_clk(7 - 16);
    tx_expect("R4 write while busy ignored", 8'h3C, 0);
    wait_clk(40);
    check("R4 no second frame", {15'h0, txd}, 16'h1);
  endtask

  task automatic t_tx_parity;
    par_gen = 1;
    bus_wr(A_TD, 16'h0007);
    tx_expect("R4 even parity 07", 8'h07, 1);
    bus_wr(A_TD, 16'h0003);
    tx_expect("R4 even parity 03", 8'h03, 1);
    par_gen = 0;
  endtask

  task automatic t_irq;
    logic [15:0] d; logic k;
    bus_wr(A_TS, 16'h0040); wait_clk(1);
    check("R3 tx request", {7'h0, tx_irq, vec}, {7'h0, 1'b1, 8'o064});
    bus_wr(A_TD, 16'h0011);
    check("R3 tx request drops while busy", {15'h0, tx_irq}, 16'h0);
    wait_clk(170);
    check("R3 tx request returns", {15'h0, tx_irq}, 16'h1);
    bus_wr(A_RS, 16'h0040);
    rx_frame(8'h5A, 0, 0, 1); wait_clk(2);
    check("R3 rx request has priority", {7'h0, rx_irq, vec}, {7'h0, 1'b1, 8'o060});
    bus_rd(A_RD, d, k);
    check("R5 rx data", d, 16'h005A);
    bus_rd(A_RS, d, k);
    check("R5 read clears done", d, 16'h0040);
    check("R3 vector back to tx", {8'h0, vec}, {8'h0, 8'o064});
    bus_wr(A_RS, 16'h0000); bus_wr(A_TS, 16'h0000);
  endtask

  task automatic t_rx_errors;
    logic [15:0] d; logic k;
    rx_frame(8'h11, 0, 0, 1); wait_clk(2);
    rx_frame(8'h22, 0, 0, 1); wait_clk(2);
    bus_rd(A_RD, d, k); check("R7 overrun", d, 16'hC022);
    rx_frame(8'h80, 0, 0, 0); rxd = 1; wait_clk(4);
    bus_rd(A_RD, d, k); check("R7 framing error", d, 16'hA080);
    rx_frame(8'h81, 0, 0, 0); rxd = 1; wait_clk(4);
    err_en = 0;
    bus_rd(A_RD, d, k); check("R7 flags masked", d, 16'h0081);
    err_en = 1;
    par_chk = 1;
    rx_frame(8'h01, 1, 0, 1); wait_clk(2);
    bus_rd(A_RD, d, k); check("R6 parity error", d, 16'h9001);
    rx_frame(8'h03, 1, 0, 1); wait_clk(2);
    bus_rd(A_RD, d, k); check("R6 good parity", d, 16'h0003);
    par_chk = 0;
  endtask

  task automatic t_break_rx;
    logic [15:0] d; logic k;
    halt_en = 1;
    rx_frame(8'h00, 0, 0, 0); wait_clk(20);
    check("R10 halt while line low", {15'h0, halt}, 16'h1);
    halt_en = 0; #1;
    check("R10 halt gated by enable", {15'h0, halt}, 16'h0);
    halt_en = 1;
    bus_rd(A_RD, d, k); check("R10 break char", d, 16'hA000);
    rxd = 1; wait_clk(6);
    check("R10 halt released with line", {15'h0, halt}, 16'h0);
    halt_en = 0;
  endtask

  task automatic t_glitch;
    logic [15:0] d; logic k;
    @(negedge clk); rxd = 0; wait_clk(4); rxd = 1;
    wait_clk(200);
    bus_rd(A_RS, d, k); check("R11 short glitch ignored", d, 16'h0000);
  endtask

  task automatic t_rate;
    logic [15:0] d; logic k;
    rx_baud = 4'd1; tx_baud = 4'd0; common = 1;
    bus_wr(A_TD, 16'h0001);
    wait_clk(24); check("R8 common rate start bit", {15'h0, txd}, 16'h0);
    wait_clk(24); check("R8 common rate data bit", {15'h0, txd}, 16'h1);
    wait_clk(152);
    bus_rd(A_TS, d, k); check("R8 still busy at slow rate", d, 16'h0000);
    wait_clk(200);
    bus_rd(A_TS, d, k); check("R8 slow frame complete", d, 16'h0080);
    rx_baud = 4'd0; common = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3); rst_n = 1; wait_clk(2);
    t_reset();
    t_decode();
    t_status_bits();
    t_tx_basic();
    t_tx_parity();
    t_irq();
    t_rx_errors();
    t_break_rx();
    t_glitch();
    t_rate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule